// File: doc/BRIEF.md
# Byte-Wide Host Register Port

This block is the device end of an 8-bit parallel host bus of the Motorola style. The bus has an active-low chip select, a data strobe, a read/write line, a two-bit register address and a byte-wide data path. All bus pins are brought into the system clock domain through two-flop synchronizers. Edges of chip select and the data strobe are found by comparing successive synchronized samples.

A host reaches two registers. The message register at address 00 moves 32-bit words. A write delivers four bytes in one chip-select window, most significant byte first, and the block hands the finished word to the core with a single-cycle strobe. A read returns a snapshot of a core-supplied word, one byte per strobe-low phase, also most significant byte first. The control register at address 01 holds one byte and is read and written one byte at a time. Addresses 10 and 11 have no register behind them.

The data path is split into an input, an output and an output enable, so that the bus driver can sit in the pad ring. The output enable is gated directly by the raw chip-select and strobe pins, so the bus is released as soon as the host lets go of either one.

Top module: `hbp_byte_port`

## Requirements
- R1: After reset, `msg_word`, `ctrl_byte`, `msg_valid`, `msg_abort`, `rd_done` and `host_data_oe` are all zero.
- R2: A write to address 00 of four bytes B0, B1, B2, B3 in one chip-select-low window puts {B0,B1,B2,B3} on `msg_word`, with B0 in bits 31:24, and raises `msg_valid` for exactly one clock.
- R3: If chip select rises after one to three message bytes have been written, those bytes are discarded, `msg_abort` pulses for one clock and `msg_valid` stays low. An access to address 00 that carries no bytes raises neither pulse.
- R4: A byte written to address 01 appears on `ctrl_byte`.
- R5: Writes to addresses 10 and 11 change neither `ctrl_byte` nor `msg_word` and raise no pulse. Reads of those addresses return 0x00.
- R6: `host_data_oe` is high only while the access is a read (R/W high when chip select fell) and both the `host_cs_n` and `host_ds` pins are low. It is never high during a write.
- R7: A read of address 00 returns bits 31:24 in the first strobe-low phase, then 23:16, 15:8 and 7:0. `rd_done` pulses once, after the strobe rises at the end of the fourth byte and not earlier.
- R8: A read of address 01 returns the current value of `ctrl_byte`.
- R9: The address is taken when chip select falls. A change of `host_addr` later in the same access does not redirect it.
- R10: The word returned by a message read is `core_tx_word` as sampled when the access begins. Changes to it during the access are not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Chip select, active low, asynchronous |
| host_ds | input | 1 | Data strobe. A rising edge latches a write byte; the low phase presents a read byte |
| host_rw | input | 1 | High for a read, low for a write |
| host_addr | input | 2 | Register address: 00 message, 01 control |
| host_data_in | input | 8 | Byte from the host bus |
| host_data_out | output | 8 | Byte toward the host bus |
| host_data_oe | output | 1 | Enable for the bus driver |
| core_tx_word | input | 32 | Word offered to host reads of the message register |
| msg_word | output | 32 | Last complete word written by the host |
| msg_valid | output | 1 | One-clock strobe when `msg_word` is updated |
| msg_abort | output | 1 | One-clock pulse when a partial message write is dropped |
| rd_done | output | 1 | One-clock pulse after the fourth byte of a message read |
| ctrl_byte | output | 8 | Control register contents |

## Verification
The assertions rely on the host keeping to the bus protocol. R/W and the address stay steady while chip select is low. Each pin level is held for several clocks, so that the synchronizers see every edge. A write byte is held on the data pins for a few clocks after the strobe rises. Chip select stays high for several clocks between accesses. The bench drives every pin on the falling clock edge and holds each level for six to eight clocks. The one exception is the deliberate address change in the R9 scenario, which happens while the strobe is high and the address has already been taken.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int IDX_W      = $clog2(WORD_BYTES);
    localparam int ADDR_W     = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_MSG   = 2'b00,
        REG_CTRL  = 2'b01,
        REG_VOID2 = 2'b10,
        REG_VOID3 = 2'b11
    } reg_sel_e;

    // Bus pins as one bundle, so they share a synchronizer.
    typedef struct packed {
        logic              cs_n;
        logic              ds;
        logic              rw;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, ds: 1'b1, rw: 1'b0,
                                   addr: '0, data: '0};

    // Access state that is held while chip select is low.
    typedef struct packed {
        logic     active;
        logic     is_read;
        reg_sel_e sel;
    } access_t;

    // Single-cycle events from the access controller.
    typedef struct packed {
        logic              start;
        logic              finish;
        logic              byte_ev;
        logic [BYTE_W-1:0] data;
    } bus_ev_t;

    // Byte idx of a word, with idx 0 as the most significant byte.
    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                    input logic [IDX_W-1:0]  idx);
        return w[(WORD_BYTES - 1 - int'(idx)) * BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] INIT   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= INIT;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= INIT;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbp_access_ctl.sv
module hbp_access_ctl
    import hbp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pins_t   syn,
    output access_t acc,
    output bus_ev_t ev
);
    logic cs_prev, ds_prev, sample_pend;
    logic cs_fall, cs_rise, ds_rise;

    always_comb begin
        cs_fall = cs_prev & ~syn.cs_n;
        cs_rise = ~cs_prev & syn.cs_n;
        ds_rise = ~ds_prev & syn.ds;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev     <= 1'b1;
            ds_prev     <= 1'b1;
            sample_pend <= 1'b0;
            acc         <= '{active: 1'b0, is_read: 1'b0, sel: REG_MSG};
            ev          <= '0;
        end else begin
            cs_prev    <= syn.cs_n;
            ds_prev    <= syn.ds;
            ev.start   <= 1'b0;
            ev.finish  <= 1'b0;
            ev.byte_ev <= 1'b0;
            if (cs_fall) begin
                acc         <= '{active: 1'b1, is_read: syn.rw, sel: reg_sel_e'(syn.addr)};
                ev.start    <= 1'b1;
                sample_pend <= 1'b0;
            end else if (cs_rise && acc.active) begin
                acc.active  <= 1'b0;
                ev.finish   <= 1'b1;
                sample_pend <= 1'b0;
            end else begin
                // Data is taken one clock after the strobe edge is seen.
                sample_pend <= ds_rise & acc.active;
                if (sample_pend) begin
                    ev.byte_ev <= 1'b1;
                    ev.data    <= syn.data;
                end
            end
        end
    end
endmodule

// File: rtl/hbp_wr_pack.sv
module hbp_wr_pack
    import hbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  bus_ev_t           ev,
    output logic [WORD_W-1:0] msg_word,
    output logic              msg_valid,
    output logic              msg_abort,
    output logic [BYTE_W-1:0] ctrl_byte
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_BYTES - 1);

    logic [WORD_W-1:0] asm_q;
    logic [IDX_W-1:0]  cnt;
    logic              have_bytes;
    logic              wr_msg, wr_ctrl;

    assign wr_msg  = ~acc.is_read && (acc.sel == REG_MSG);
    assign wr_ctrl = ~acc.is_read && (acc.sel == REG_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            asm_q      <= '0;
            cnt        <= '0;
            have_bytes <= 1'b0;
            msg_word   <= '0;
            msg_valid  <= 1'b0;
            msg_abort  <= 1'b0;
            ctrl_byte  <= '0;
        end else begin
            msg_valid <= 1'b0;
            msg_abort <= 1'b0;
            if (ev.start) begin
                cnt        <= '0;
                have_bytes <= 1'b0;
            end else if (ev.finish) begin
                if (wr_msg && have_bytes) msg_abort <= 1'b1;
                cnt        <= '0;
                have_bytes <= 1'b0;
            end else if (ev.byte_ev) begin
                if (wr_msg) begin
                    asm_q <= {asm_q[WORD_W-BYTE_W-1:0], ev.data};
                    if (cnt == LAST) begin
                        msg_word   <= {asm_q[WORD_W-BYTE_W-1:0], ev.data};
                        msg_valid  <= 1'b1;
                        cnt        <= '0;
                        have_bytes <= 1'b0;
                    end else begin
                        cnt        <= cnt + 1'b1;
                        have_bytes <= 1'b1;
                    end
                end
                if (wr_ctrl) ctrl_byte <= ev.data;
            end
        end
    end
endmodule

// File: rtl/hbp_rd_path.sv
module hbp_rd_path
    import hbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  bus_ev_t           ev,
    input  logic [WORD_W-1:0] core_tx_word,
    input  logic [BYTE_W-1:0] ctrl_byte,
    input  logic              pin_cs_n,
    input  logic              pin_ds,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe,
    output logic              rd_done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_BYTES - 1);

    logic [WORD_W-1:0] snap;
    logic [IDX_W-1:0]  idx;
    logic              rd_msg;
    logic [BYTE_W-1:0] sel_byte;

    assign rd_msg = acc.is_read && (acc.sel == REG_MSG);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap    <= '0;
            idx     <= '0;
            rd_done <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            if (ev.start) begin
                idx  <= '0;
                snap <= core_tx_word;
            end else if (ev.byte_ev && rd_msg) begin
                if (idx == LAST) begin
                    idx     <= '0;
                    rd_done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        unique case (acc.sel)
            REG_MSG:  sel_byte = pick_byte(snap, idx);
            REG_CTRL: sel_byte = ctrl_byte;
            default:  sel_byte = '0;
        endcase
    end

    // The raw pins gate the enable, so the bus is released at once.
    assign data_oe  = acc.active & acc.is_read & ~pin_cs_n & ~pin_ds;
    assign data_out = data_oe ? sel_byte : '0;
endmodule

// File: rtl/hbp_byte_port.sv
module hbp_byte_port
    import hbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs_n,
    input  logic              host_ds,
    input  logic              host_rw,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_data_in,
    output logic [BYTE_W-1:0] host_data_out,
    output logic              host_data_oe,
    input  logic [WORD_W-1:0] core_tx_word,
    output logic [WORD_W-1:0] msg_word,
    output logic              msg_valid,
    output logic              msg_abort,
    output logic              rd_done,
    output logic [BYTE_W-1:0] ctrl_byte
);
    pins_t   raw, syn;
    access_t acc;
    bus_ev_t ev;

    assign raw = '{cs_n: host_cs_n, ds: host_ds, rw: host_rw,
                   addr: host_addr, data: host_data_in};

    hbp_sync #(
        .W      ($bits(pins_t)),
        .STAGES (SYNC_STAGES),
        .INIT   (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    hbp_access_ctl u_ctl (
        .clk (clk),
        .rst (rst),
        .syn (syn),
        .acc (acc),
        .ev  (ev)
    );

    hbp_wr_pack u_wr (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .ev        (ev),
        .msg_word  (msg_word),
        .msg_valid (msg_valid),
        .msg_abort (msg_abort),
        .ctrl_byte (ctrl_byte)
    );

    hbp_rd_path u_rd (
        .clk          (clk),
        .rst          (rst),
        .acc          (acc),
        .ev           (ev),
        .core_tx_word (core_tx_word),
        .ctrl_byte    (ctrl_byte),
        .pin_cs_n     (host_cs_n),
        .pin_ds       (host_ds),
        .data_out     (host_data_out),
        .data_oe      (host_data_oe),
        .rd_done      (rd_done)
    );
endmodule

// File: rtl/hbp_port_checker.sv
module hbp_port_checker (
    input logic clk,
    input logic rst,
    input logic host_cs_n,
    input logic host_ds,
    input logic host_rw,
    input logic host_data_oe,
    input logic msg_valid,
    input logic msg_abort,
    input logic rd_done
);
    // R6: the driver is on only while both raw strobes are low
    a_r6_oe_needs_strobes: assert property (@(posedge clk) disable iff (rst)
        host_data_oe |-> (!host_cs_n && !host_ds));

    // R6: the driver is never on while the host signals a write
    a_r6_oe_read_only: assert property (@(posedge clk) disable iff (rst)
        host_data_oe |-> host_rw);

    // R2: a completed word is announced for a single clock
    a_r2_valid_single: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> !msg_valid);

    // R3: a dropped word and a completed word never coincide
    a_r3_abort_not_valid: assert property (@(posedge clk) disable iff (rst)
        !(msg_valid && msg_abort));

    // R3: a partial word is dropped only once chip select is released
    a_r3_abort_after_release: assert property (@(posedge clk) disable iff (rst)
        msg_abort |-> host_cs_n);

    // R7: the read completion is a single-clock pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);
endmodule

bind hbp_byte_port hbp_port_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_cs_n    (host_cs_n),
    .host_ds      (host_ds),
    .host_rw      (host_rw),
    .host_data_oe (host_data_oe),
    .msg_valid    (msg_valid),
    .msg_abort    (msg_abort),
    .rd_done      (rd_done)
);

// File: tb/hbp_byte_port_tb_top.sv
module hbp_byte_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_cs_n = 1'b1;
    logic        host_ds = 1'b1;
    logic        host_rw = 1'b0;
    logic [1:0]  host_addr = 2'b00;
    logic [7:0]  host_data_in = 8'h00;
    logic [7:0]  host_data_out;
    logic        host_data_oe;
    logic [31:0] core_tx_word = 32'h0;
    logic [31:0] msg_word;
    logic        msg_valid, msg_abort, rd_done;
    logic [7:0]  ctrl_byte;

    int n_checks = 0;
    int n_err = 0;
    int n_valid = 0;
    int n_abort = 0;
    int n_done = 0;
    logic [31:0] last_word = 32'h0;
    bit finished = 0;

    always #5 clk = ~clk;

    hbp_byte_port dut_i (
        .clk           (clk),
        .rst           (rst),
        .host_cs_n     (host_cs_n),
        .host_ds       (host_ds),
        .host_rw       (host_rw),
        .host_addr     (host_addr),
        .host_data_in  (host_data_in),
        .host_data_out (host_data_out),
        .host_data_oe  (host_data_oe),
        .core_tx_word  (core_tx_word),
        .msg_word      (msg_word),
        .msg_valid     (msg_valid),
        .msg_abort     (msg_abort),
        .rd_done       (rd_done),
        .ctrl_byte     (ctrl_byte)
    );

    // Pulse monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (!rst) begin
            if (msg_valid) begin
                n_valid++;
                last_word = msg_word;
            end
            if (msg_abort) n_abort++;
            if (rd_done)   n_done++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic open_access(input logic rw, input logic [1:0] a);
        host_rw   = rw;
        host_addr = a;
        cyc(2);
        host_cs_n = 1'b0;
        cyc(6);
    endtask

    task automatic close_access();
        host_cs_n = 1'b1;
        cyc(8);
        host_rw = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        host_ds      = 1'b0;
        host_data_in = b;
        cyc(6);
        chk("R6 write oe", {31'h0, host_data_oe}, 32'h0);
        host_ds = 1'b1;
        cyc(6);
    endtask

    task automatic get_byte(input string req, input logic [7:0] exp);
        host_ds = 1'b0;
        cyc(6);
        chk("R6 read oe", {31'h0, host_data_oe}, 32'h1);
        chk(req, {24'h0, host_data_out}, {24'h0, exp});
        host_ds = 1'b1;
        cyc(6);
    endtask

    task automatic t_reset();
        chk("R1 msg_word", msg_word, 32'h0);
        chk("R1 ctrl_byte", {24'h0, ctrl_byte}, 32'h0);
        chk("R1 pulses", {29'h0, msg_valid, msg_abort, rd_done}, 32'h0);
        chk("R1 oe", {31'h0, host_data_oe}, 32'h0);
    endtask

    task automatic t_msg_write(input logic [31:0] w);
        int v0 = n_valid;
        int a0 = n_abort;
        open_access(1'b0, 2'b00);
        for (int i = 3; i >= 0; i--) put_byte(w[i*8 +: 8]);
        close_access();
        chk("R2 valid count", n_valid, v0 + 1);
        chk("R2 word order", last_word, w);
        chk("R2 no abort", n_abort, a0);
    endtask

    task automatic t_partial(input int nbytes);
        int v0 = n_valid;
        int a0 = n_abort;
        logic [31:0] w0 = msg_word;
        open_access(1'b0, 2'b00);
        for (int i = 0; i < nbytes; i++) put_byte(8'hC0 + 8'(i));
        close_access();
        chk("R3 abort count", n_abort, a0 + ((nbytes > 0) ? 1 : 0));
        chk("R3 no valid", n_valid, v0);
        chk("R3 word kept", msg_word, w0);
    endtask

    task automatic t_ctrl_write(input logic [7:0] b);
        open_access(1'b0, 2'b01);
        put_byte(b);
        close_access();
        chk("R4 ctrl_byte", {24'h0, ctrl_byte}, {24'h0, b});
    endtask

    task automatic t_void_addr();
        logic [7:0]  c0 = ctrl_byte;
        logic [31:0] w0 = msg_word;
        int v0 = n_valid;
        int a0 = n_abort;
        for (int a = 2; a < 4; a++) begin
            open_access(1'b0, 2'(a));
            for (int i = 0; i < 4; i++) put_byte(8'h3C);
            close_access();
        end
        chk("R5 ctrl unchanged", {24'h0, ctrl_byte}, {24'h0, c0});
        chk("R5 word unchanged", msg_word, w0);
        chk("R5 no pulses", n_valid + n_abort, v0 + a0);
        open_access(1'b1, 2'b10);
        get_byte("R5 read 10", 8'h00);
        close_access();
        open_access(1'b1, 2'b11);
        get_byte("R5 read 11", 8'h00);
        close_access();
    endtask

    task automatic t_msg_read(input logic [31:0] w);
        int d0 = n_done;
        core_tx_word = w;
        open_access(1'b1, 2'b00);
        chk("R6 oe with ds high", {31'h0, host_data_oe}, 32'h0);
        core_tx_word = ~w;
        for (int i = 3; i >= 0; i--) begin
            get_byte($sformatf("R7 R10 byte %0d", 3 - i), w[i*8 +: 8]);
            if (i == 1) chk("R7 no early done", n_done, d0);
        end
        chk("R7 done count", n_done, d0 + 1);
        close_access();
        chk("R6 oe after release", {31'h0, host_data_oe}, 32'h0);
    endtask

    task automatic t_ctrl_read(input logic [7:0] exp);
        open_access(1'b1, 2'b01);
        get_byte("R8 ctrl read", exp);
        close_access();
    endtask

    task automatic t_addr_hold();
        int a0 = n_abort;
        int v0 = n_valid;
        open_access(1'b0, 2'b01);
        host_addr = 2'b00;
        cyc(4);
        put_byte(8'h5A);
        close_access();
        chk("R9 ctrl got byte", {24'h0, ctrl_byte}, 32'h5A);
        chk("R9 no message side effect", n_abort + n_valid, a0 + v0);
    endtask

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(3);
        t_reset();
        t_msg_write(32'h1234_5678);
        t_msg_write(32'hA5C3_0FF0);
        t_partial(1);
        t_partial(3);
        t_partial(0);
        t_ctrl_write(8'h96);
        t_void_addr();
        t_msg_read(32'hDEAD_BEEF);
        t_msg_read(32'h0102_0304);
        t_ctrl_read(8'h96);
        t_addr_hold();
        t_ctrl_read(8'h5A);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule